// File: doc/BRIEF.md
# Banked GPIO Register File

This block holds the configuration and status registers for a bank of up to 56 general-purpose pins. The pins are numbered from 1 and packed eight to a byte. For each pin there is a function-select bit, a direction bit, an output-latch bit, a pull-down enable bit and a read-only level bit. The block also has three single registers:
- an alternate-function byte;
- a 2-bit input-voltage select;
- a register of 2-bit pull fields, one field for each pin in a fixed range (51 to 54 by default).

A host reaches every register through a synchronous 8-bit port. Writes take effect at the clock edge where `we_i` is high. Reads are registered: `rdata_o` holds the addressed byte from the edge after `re_i` is sampled. The block drives pad controls straight from its state: output enable, output value, pull-down and pull-up for each pin, plus the select bits, the alternate-function byte and the voltage select. Pad levels come back through a two-flop synchronizer before they can be read.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every pad is an input (`pad_oe_o` all 0). All select, output-latch and pull-down bits are 0, the alternate-function byte is 0x00, the voltage select is 0, every 2-bit pull field holds 1 (register 0x48 reads 0x55) and `rdata_o` is 0x00.
- R2: Pin n (n ≥ 1, no pin 0) lives at byte address base + (n−1)/8, bit (n−1) mod 8. The group bases are: select 0x00, direction 0x10, output latch 0x20, pull-down enable 0x30, input level 0x40. The writable groups read back the last value written.
- R3: A direction bit of 1 sets the pin's `pad_oe_o` bit; a 0 clears it. `pad_out_o` follows the output-latch bit, and `func_sel_o` follows the select bit.
- R4: A read of an input register (0x40–0x46) returns the pad levels sampled through two synchronizer flops. A pad change is seen by any read issued three or more cycles later.
- R5: Writes to the input registers change no register and no pad output.
- R6: Register 0x48 holds a 2-bit pull field for each pin p in 51..54, at bits [(p−51)×2+1 : (p−51)×2]. Value 0 asserts that pin's `pad_pd_o`, value 3 asserts its `pad_pu_o`, and values 1 and 2 assert neither.
- R7: Every pin outside 51..54 gets `pad_pd_o` equal to its pull-down enable bit (1 = enabled), and its `pad_pu_o` stays 0.
- R8: For pins 51..54, the pull-down enable bit has no effect on `pad_pd_o` or `pad_pu_o`, although it still reads back.
- R9: Register 0x47 stores only bits [1:0], which drive `vin_sel_o`. It reads back with bits [7:2] as 0.
- R10: Register 0x50 stores a full byte that drives `alt_func_o`.
- R11: Every other address reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pad_in_i | input | 56 | Pad levels, bit k is pin k+1 |
| pad_oe_o | output | 56 | Output enable for each pin |
| pad_out_o | output | 56 | Output value for each pin |
| pad_pd_o | output | 56 | Pull-down enable for each pin |
| pad_pu_o | output | 56 | Pull-up enable for each pin |
| func_sel_o | output | 56 | Function-select bit for each pin |
| alt_func_o | output | 8 | Alternate-function byte |
| vin_sel_o | output | 2 | Input-voltage select |

## Verification
The bench targets the following corner cases:
- The first and last pins (bit 0 of 0x10, bit 7 of 0x16). A design that computed the bank or bit from n instead of n−1 would move these pins by one.
- Pins 50 and 55 on either side of the 2-bit pull range, and all four field codes on pins 51..54. A wrong range bound or a misdecoded code would show up as a stray pull on `pad_pd_o` or `pad_pu_o`.
- Writes to the input registers, to address 0x47 with upper bits set, and to holes such as 0x07, 0x17 and 0x49. A design that aliased these addresses or stored the extra bits would corrupt the live registers or return nonzero data.

Random write sequences are checked against a bench model after every write, and every address is then read back.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam logic [3:0] GRP_SEL = 4'h0;
  localparam logic [3:0] GRP_DIR = 4'h1;
  localparam logic [3:0] GRP_OUT = 4'h2;
  localparam logic [3:0] GRP_PD  = 4'h3;
  localparam logic [3:0] GRP_IN  = 4'h4;
  localparam logic [7:0] ADDR_VIN  = 8'h47;
  localparam logic [7:0] ADDR_PULL = 8'h48;
  localparam logic [7:0] ADDR_ALT  = 8'h50;
  localparam logic [1:0] PULL_DOWN = 2'd0;
  localparam logic [1:0] PULL_UP   = 2'd3;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH = 56
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_bank_cfg.sv
module gpio_bank_cfg
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 7,
  parameter int PU_COUNT  = 4,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int PW = 2 * PU_COUNT
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [7:0]                addr_i,
  input  logic [7:0]                wdata_i,
  output logic [NUM_BANKS-1:0][7:0] sel_o,
  output logic [NUM_BANKS-1:0][7:0] dir_o,
  output logic [NUM_BANKS-1:0][7:0] out_o,
  output logic [NUM_BANKS-1:0][7:0] pd_o,
  output logic [PW-1:0]             pull_o,
  output logic [1:0]                vin_o,
  output logic [7:0]                alt_o
);
  localparam logic [3:0] NB4 = 4'(NUM_BANKS);

  logic [NUM_BANKS-1:0][7:0] sel_q, dir_q, out_q, pd_q;
  logic [PW-1:0] pull_q;
  logic [1:0]    vin_q;
  logic [7:0]    alt_q;

  logic [3:0]    grp;
  logic [3:0]    idx;
  logic          bank_hit;
  logic [BW-1:0] bidx;

  assign grp      = addr_i[7:4];
  assign idx      = addr_i[3:0];
  assign bank_hit = idx < NB4;
  assign bidx     = idx[BW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      pd_q   <= '0;
      pull_q <= {PU_COUNT{2'b01}};
      vin_q  <= '0;
      alt_q  <= '0;
    end else if (we_i) begin
      if (bank_hit) begin
        unique case (grp)
          GRP_SEL: sel_q[bidx] <= wdata_i;
          GRP_DIR: dir_q[bidx] <= wdata_i;
          GRP_OUT: out_q[bidx] <= wdata_i;
          GRP_PD:  pd_q[bidx]  <= wdata_i;
          default: ;
        endcase
      end
      if (addr_i == ADDR_VIN)  vin_q  <= wdata_i[1:0];
      if (addr_i == ADDR_PULL) pull_q <= wdata_i[PW-1:0];
      if (addr_i == ADDR_ALT)  alt_q  <= wdata_i;
    end
  end

  assign sel_o  = sel_q;
  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign pd_o   = pd_q;
  assign pull_o = pull_q;
  assign vin_o  = vin_q;
  assign alt_o  = alt_q;

  p_dir_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && grp == GRP_DIR && bank_hit) |=> dir_q[$past(bidx)] == $past(wdata_i));

  p_input_write_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && grp == GRP_IN && bank_hit) |=>
      ($stable(sel_q) && $stable(dir_q) && $stable(out_q) && $stable(pd_q) &&
       $stable(pull_q) && $stable(vin_q) && $stable(alt_q)));

  p_vin_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_VIN) |=> vin_q == $past(wdata_i[1:0]));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 56,
  parameter int PU_FIRST = 51,
  parameter int PU_COUNT = 4,
  localparam int NUM_BANKS = (NUM_PINS + 7) / 8,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int PW = 2 * PU_COUNT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [7:0]          addr_i,
  input  logic [7:0]          wdata_i,
  input  logic                we_i,
  input  logic                re_i,
  output logic [7:0]          rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_pd_o,
  output logic [NUM_PINS-1:0] pad_pu_o,
  output logic [NUM_PINS-1:0] func_sel_o,
  output logic [7:0]          alt_func_o,
  output logic [1:0]          vin_sel_o
);
  localparam logic [3:0] NB4 = 4'(NUM_BANKS);
  localparam int FLAT = NUM_BANKS * 8;

  logic [NUM_BANKS-1:0][7:0] sel_b, dir_b, out_b, pd_b, in_b;
  logic [FLAT-1:0] sel_f, dir_f, out_f, pd_f, in_f;
  logic [NUM_PINS-1:0] in_sync;
  logic [PW-1:0] pull_f;
  logic [1:0]    vin_f;
  logic [7:0]    alt_f;

  gpio_bank_cfg #(.NUM_BANKS(NUM_BANKS), .PU_COUNT(PU_COUNT)) u_cfg (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .sel_o(sel_b), .dir_o(dir_b), .out_o(out_b), .pd_o(pd_b),
    .pull_o(pull_f), .vin_o(vin_f), .alt_o(alt_f)
  );

  gpio_bank_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(in_sync)
  );

  assign sel_f = sel_b;
  assign dir_f = dir_b;
  assign out_f = out_b;
  assign pd_f  = pd_b;
  assign in_f  = FLAT'(in_sync);
  assign in_b  = in_f;

  assign pad_oe_o   = dir_f[NUM_PINS-1:0];
  assign pad_out_o  = out_f[NUM_PINS-1:0];
  assign func_sel_o = sel_f[NUM_PINS-1:0];
  assign alt_func_o = alt_f;
  assign vin_sel_o  = vin_f;

  // pins in the 2-bit field range ignore their pull-down bit
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pull
    if ((p + 1 >= PU_FIRST) && (p + 1 < PU_FIRST + PU_COUNT)) begin : g_field
      localparam int K = p + 1 - PU_FIRST;
      assign pad_pd_o[p] = pull_f[2*K +: 2] == PULL_DOWN;
      assign pad_pu_o[p] = pull_f[2*K +: 2] == PULL_UP;
    end else begin : g_bit
      assign pad_pd_o[p] = pd_f[p];
      assign pad_pu_o[p] = 1'b0;
    end
  end

  logic [3:0]    grp, idx;
  logic          bank_hit;
  logic [BW-1:0] bidx;
  logic [7:0]    rd_d;

  assign grp      = addr_i[7:4];
  assign idx      = addr_i[3:0];
  assign bank_hit = idx < NB4;
  assign bidx     = idx[BW-1:0];

  always_comb begin
    rd_d = 8'h00;
    if (bank_hit) begin
      unique case (grp)
        GRP_SEL: rd_d = sel_b[bidx];
        GRP_DIR: rd_d = dir_b[bidx];
        GRP_OUT: rd_d = out_b[bidx];
        GRP_PD:  rd_d = pd_b[bidx];
        GRP_IN:  rd_d = in_b[bidx];
        default: rd_d = 8'h00;
      endcase
    end
    if (addr_i == ADDR_VIN)  rd_d = {6'b0, vin_f};
    if (addr_i == ADDR_PULL) rd_d = 8'(pull_f);
    if (addr_i == ADDR_ALT)  rd_d = alt_f;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= 8'h00;
    else if (re_i) rdata_o <= rd_d;
  end

  logic mapped;
  assign mapped = (grp <= GRP_IN && bank_hit) || addr_i == ADDR_VIN ||
                  addr_i == ADDR_PULL || addr_i == ADDR_ALT;

  p_unmapped_read_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !mapped) |=> rdata_o == 8'h00);

  p_vin_upper_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == ADDR_VIN) |=> rdata_o[7:2] == 6'b0);

  p_pull_exclusive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pd_o & pad_pu_o) == '0);

  p_pu_range_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pad_pu_o) <= PU_COUNT);
endmodule

// File: tb/sim_gpio_bank_regs.sv
module sim_gpio_bank_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 56;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic we = 1'b0, re = 1'b0;
  logic [7:0] rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_oe, pad_out, pad_pd, pad_pu, func_sel;
  logic [7:0] alt_func;
  logic [1:0] vin_sel;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_oe_o(pad_oe), .pad_out_o(pad_out), .pad_pd_o(pad_pd),
    .pad_pu_o(pad_pu), .func_sel_o(func_sel), .alt_func_o(alt_func),
    .vin_sel_o(vin_sel)
  );

  logic [7:0] m_sel[7], m_dir[7], m_out[7], m_pd[7];
  logic [7:0] m_pull, m_alt;
  logic [1:0] m_vin;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    logic [3:0] g = a[7:4];
    int i = int'(a[3:0]);
    if (g <= 4'h4 && i < 7) begin
      case (g)
        4'h0: return m_sel[i];
        4'h1: return m_dir[i];
        4'h2: return m_out[i];
        4'h3: return m_pd[i];
        default: return pad_in[i*8 +: 8];
      endcase
    end
    if (a == 8'h47) return {6'b0, m_vin};
    if (a == 8'h48) return m_pull;
    if (a == 8'h50) return m_alt;
    return 8'h00;
  endfunction

  function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
    logic [3:0] g = a[7:4];
    int i = int'(a[3:0]);
    if (i < 7) begin
      case (g)
        4'h0: m_sel[i] = d;
        4'h1: m_dir[i] = d;
        4'h2: m_out[i] = d;
        4'h3: m_pd[i] = d;
        default: ;
      endcase
    end
    if (a == 8'h47) m_vin = d[1:0];
    if (a == 8'h48) m_pull = d;
    if (a == 8'h50) m_alt = d;
  endfunction

  function automatic logic [NP-1:0] flat(input int which);
    logic [NP-1:0] v;
    for (int b = 0; b < 7; b++)
      case (which)
        0: v[b*8 +: 8] = m_sel[b];
        1: v[b*8 +: 8] = m_dir[b];
        2: v[b*8 +: 8] = m_out[b];
        default: v[b*8 +: 8] = m_pd[b];
      endcase
    return v;
  endfunction

  function automatic logic [NP-1:0] exp_pd();
    logic [NP-1:0] v = flat(3);
    for (int p = 51; p <= 54; p++) v[p-1] = (m_pull[(p-51)*2 +: 2] == 2'd0);
    return v;
  endfunction

  function automatic logic [NP-1:0] exp_pu();
    logic [NP-1:0] v = '0;
    for (int p = 51; p <= 54; p++) v[p-1] = (m_pull[(p-51)*2 +: 2] == 2'd3);
    return v;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    chk(req, 64'(rdata), 64'(exp_rd(a)));
  endtask

  task automatic pads_chk(input string tag);
    chk({tag, " R3 oe"}, 64'(pad_oe), 64'(flat(1)));
    chk({tag, " R3 out"}, 64'(pad_out), 64'(flat(2)));
    chk({tag, " R3 sel"}, 64'(func_sel), 64'(flat(0)));
    chk({tag, " R6 R7 R8 pd"}, 64'(pad_pd), 64'(exp_pd()));
    chk({tag, " R6 R7 pu"}, 64'(pad_pu), 64'(exp_pu()));
    chk({tag, " R10 alt"}, 64'(alt_func), 64'(m_alt));
    chk({tag, " R9 vin"}, 64'(vin_sel), 64'(m_vin));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int b = 0; b < 7; b++) begin
      m_sel[b] = 0; m_dir[b] = 0; m_out[b] = 0; m_pd[b] = 0;
    end
    m_pull = 8'h55; m_alt = 0; m_vin = 0;
    #(CLK_PERIOD * 3);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk("R1 rdata", 64'(rdata), 64'h0);
    chk("R1 oe", 64'(pad_oe), 64'h0);
    chk("R1 pd", 64'(pad_pd), 64'h0);
    chk("R1 pu", 64'(pad_pu), 64'h0);
    rd_chk("R1 pull reset", 8'h48);
    chk("R1 pull value", 64'(rdata), 64'h55);

    // R2 R3 first and last pins
    wr(8'h10, 8'h01);
    chk("R2 pin1 oe", 64'(pad_oe), 64'h1);
    wr(8'h16, 8'h80);
    chk("R2 pin56 oe", 64'(pad_oe[55]), 64'h1);
    rd_chk("R2 dir bank6", 8'h16);
    wr(8'h20, 8'hA5);
    pads_chk("R3 out");

    // R7 pins 50 and 55; R8 range pd bits ignored
    wr(8'h36, 8'b0100_0010);
    chk("R7 pin50 pd", 64'(pad_pd[49]), 64'h1);
    chk("R7 pin55 pd", 64'(pad_pd[54]), 64'h1);
    wr(8'h36, 8'h3C);
    chk("R8 pd bits ignored", 64'(pad_pd[53:50]), 64'h0);
    rd_chk("R8 pd readback", 8'h36);
    // R6 each code
    wr(8'h48, 8'b11_10_01_00);
    chk("R6 pd codes", 64'(pad_pd[53:50]), 64'b0001);
    chk("R6 pu codes", 64'(pad_pu[53:50]), 64'b1000);
    wr(8'h48, 8'b00_11_10_01);
    pads_chk("R6 rot");

    // R9 upper bits dropped
    wr(8'h47, 8'hFF);
    rd_chk("R9 vin readback", 8'h47);
    chk("R9 vin value", 64'(rdata), 64'h03);
    wr(8'h50, 8'h5A);
    pads_chk("R10");

    // R4 input sync, R5 input write ignored
    pad_in = 56'hDE_AD_BE_EF_01_23_45;
    repeat (3) @(negedge clk);
    for (int b = 0; b < 7; b++) rd_chk("R4 input", 8'(8'h40 + b));
    wr(8'h43, 8'h00);
    rd_chk("R5 input after write", 8'h43);
    pads_chk("R5");

    // R11 holes
    foreach (m_sel[i]) ;
    wr(8'h07, 8'hFF); wr(8'h17, 8'hFF); wr(8'h49, 8'hFF); wr(8'hFF, 8'hFF);
    pads_chk("R11 after hole writes");
    rd_chk("R11 hole 07", 8'h07);
    rd_chk("R11 hole 49", 8'h49);
    rd_chk("R11 hole FF", 8'hFF);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      case ($urandom_range(0, 3))
        0: a = 8'($urandom_range(0, 255));
        1: a = (8'($urandom_range(0, 4)) << 4) | 8'($urandom_range(0, 7));
        2: a = 8'($urandom_range(8'h47, 8'h48));
        default: a = 8'h50;
      endcase
      wr(a, 8'($urandom));
      if (n % 50 == 0) begin
        pad_in = {24'($urandom), 32'($urandom)};
        repeat (3) @(negedge clk);
      end
      pads_chk("R2 random");
    end
    for (int a = 0; a < 96; a++) rd_chk("R2 R11 sweep", 8'(a));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule